// File: doc/BRIEF.md
# Step Attenuator Digital Control Front End

This block is the digital control logic that sits in front of a six-bit binary-weighted step attenuator. It takes the attenuation setting from one of two sources, picked by a mode-select input. The first source is a three-wire serial stream: data, clock and a latch strobe. The second is six parallel control bits. The block keeps the active setting in a register and drives one bypass-switch select per attenuator section. Bit 0 selects the 0.5 dB section. Bits 1 to 5 select the 1, 2, 4, 8 and 16 dB sections. The total attenuation is the sum of the selected sections, so the six-bit code is also the attenuation in half-dB units.

A serial data output repeats the serial input stream through an eight-stage shift chain. Several attenuators can therefore sit on one serial bus in a daisy chain, as long as every device is sent eight-bit words. The latch input has a different meaning in each mode:
- In serial mode, its rising edge loads the setting, and while it is high the serial clock is masked.
- In parallel mode, holding it high makes the switches follow the parallel pins directly. Bringing it low freezes the last value.

All pin inputs are resynchronised to the block clock through a configurable number of flop stages. The serial clock and latch edges are then detected in that clock domain.

Top module: `atten_ctrl`

## Requirements
- R1: A synchronous reset drives `atten_sel` to 0 (the 0 dB reference) and clears the shift chain, so `ser_out` reads 0 in the cycle after reset.
- R2: With `mode_ser` high and `latch_en` low, each rising edge of the serial clock pin `ctl_pin[5]` shifts the level on the serial data pin `ctl_pin[4]` into the chain, most significant bit first. A rising edge of `latch_en` then copies the last six bits shifted into `atten_sel`. Bit i of `atten_sel` selects the section weighing 2^i half-dB units.
- R3: In an eight-bit serial word, the first two bits shifted in have no effect on `atten_sel`.
- R4: In serial mode, serial clock edges that arrive while `latch_en` is high do not shift the chain.
- R5: After the k-th shift since reset, `ser_out` equals the bit shifted in at shift k-7, and it is 0 before the eighth shift. This is an eight-edge delay from input to output.
- R6: In serial mode, `atten_sel` changes only on a rising edge of `latch_en`. Shifting without a latch leaves it unchanged.
- R7: With `mode_ser` low and `latch_en` high, `atten_sel` follows `ctl_pin[5:0]` continuously, within SYNC_STAGES+2 clock cycles.
- R8: With `mode_ser` low and `latch_en` low, changes on `ctl_pin` do not affect `atten_sel`. It holds the value present while `latch_en` was last high.
- R9: In parallel mode, toggling the serial clock and data pins does not shift the chain. `ser_out` stays unchanged, and a later serial latch loads the chain contents from before the toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ser | input | 1 | 1 = serial control, 0 = parallel control |
| latch_en | input | 1 | Latch strobe (serial load edge / parallel transparency) |
| ctl_pin | input | CODE_W | Parallel control bits. In serial mode, bit 4 is serial data and bit 5 is serial clock |
| ser_out | output | 1 | Daisy-chain serial output (end of the eight-stage chain) |
| atten_sel | output | CODE_W | Bypass-switch selects; the value is the attenuation in 0.5 dB units |

## Verification
Every one of the 64 codes is sent as a six-bit serial word and again as an eight-bit word with varying leading bits. This separates bit order and weighting errors from failures to discard the leading bits. A sixteen-bit stream with reset-cleared chain history is used to tell an eight-edge delay on `ser_out` from a seven- or nine-edge one. The parallel sweeps run all 64 values with the latch held high, and then again with the latch held low and a pulse between values. Together they separate transparent tracking from frozen hold. Serial clock edges sent under a high latch and in parallel mode show whether the masking of shifts holds.

// File: rtl/atten_pkg.sv
package atten_pkg;

   typedef enum logic {
      CTRL_PARALLEL = 1'b0,
      CTRL_SERIAL   = 1'b1
   } ctrl_mode_e;

   localparam int unsigned DEF_CODE_W    = 6;
   localparam int unsigned DEF_CHAIN_LEN = 8;
   localparam int unsigned DEF_SYNC      = 2;

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/atten_shift_chain.sv
module atten_shift_chain #(
   parameter int unsigned LEN = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic           din,
   output logic [LEN-1:0] chain_q,
   output logic           dout
);

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else if (shift_en) begin
         chain_q <= {chain_q[LEN-2:0], din};
      end
   end

   assign dout = chain_q[LEN-1];

endmodule

// File: rtl/atten_code_reg.sv
module atten_code_reg #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] code_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
      end else if (load_en) begin
         code_q <= load_val;
      end
   end

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
   import atten_pkg::*;
#(
   parameter int unsigned CODE_W      = DEF_CODE_W,
   parameter int unsigned CHAIN_LEN   = DEF_CHAIN_LEN,
   parameter int unsigned SYNC_STAGES = DEF_SYNC,
   parameter int unsigned DATA_PIN    = 4,
   parameter int unsigned SCLK_PIN    = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_ser,
   input  logic              latch_en,
   input  logic [CODE_W-1:0] ctl_pin,
   output logic              ser_out,
   output logic [CODE_W-1:0] atten_sel
);

   localparam int unsigned BUS_W = CODE_W + 2;

   generate
      if (CHAIN_LEN < CODE_W + 1) begin : g_bad_chain
         $error("atten_ctrl: CHAIN_LEN must exceed CODE_W");
      end
      if (DATA_PIN >= CODE_W || SCLK_PIN >= CODE_W || DATA_PIN == SCLK_PIN) begin : g_bad_pin
         $error("atten_ctrl: serial pin indices must be distinct and below CODE_W");
      end
   endgenerate

   logic [BUS_W-1:0]  raw_bus;
   logic [BUS_W-1:0]  sync_bus;
   logic              s_mode;
   logic              s_le;
   logic [CODE_W-1:0] s_par;
   logic              sck_prev;
   logic              le_prev;
   logic              sck_rise;
   logic              le_rise;
   logic              shift_en;
   logic              load_en;
   logic [CODE_W-1:0] load_val;
   logic [CHAIN_LEN-1:0] chain_q;
   ctrl_mode_e        cur_mode;

   assign raw_bus = {mode_ser, latch_en, ctl_pin};

   atten_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_bus),
      .q   (sync_bus)
   );

   assign s_mode   = sync_bus[BUS_W-1];
   assign s_le     = sync_bus[BUS_W-2];
   assign s_par    = sync_bus[CODE_W-1:0];
   assign cur_mode = ctrl_mode_e'(s_mode);

   always_ff @(posedge clk) begin
      if (rst) begin
         sck_prev <= 1'b0;
         le_prev  <= 1'b0;
      end else begin
         sck_prev <= s_par[SCLK_PIN];
         le_prev  <= s_le;
      end
   end

   assign sck_rise = s_par[SCLK_PIN] & ~sck_prev;
   assign le_rise  = s_le & ~le_prev;

   // Shift only in serial mode with the latch low; a high latch masks the clock.
   assign shift_en = (cur_mode == CTRL_SERIAL) && !s_le && sck_rise;

   atten_shift_chain #(.LEN(CHAIN_LEN)) i_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .din      (s_par[DATA_PIN]),
      .chain_q  (chain_q),
      .dout     (ser_out)
   );

   always_comb begin
      if (cur_mode == CTRL_SERIAL) begin
         load_en  = le_rise;
         load_val = chain_q[CODE_W-1:0];
      end else begin
         load_en  = s_le;
         load_val = s_par;
      end
   end

   atten_code_reg #(.WIDTH(CODE_W)) i_code (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .load_val (load_val),
      .code_q   (atten_sel)
   );

endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
   parameter int unsigned CODE_W    = 6,
   parameter int unsigned CHAIN_LEN = 8
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 s_mode,
   input logic                 s_le,
   input logic                 sck_rise,
   input logic                 le_rise,
   input logic [CODE_W-1:0]    s_par,
   input logic [CHAIN_LEN-1:0] chain_q,
   input logic                 ser_out,
   input logic [CODE_W-1:0]    atten_sel
);

   logic past_rst = 1'b0;

   always_ff @(posedge clk) begin
      past_rst <= rst;
      if (past_rst) begin
         // R1
         reset_clear_chk: assert (atten_sel == '0 && ser_out == 1'b0 && chain_q == '0);
      end
   end

   // R2
   ser_load_chk: assert property (@(posedge clk) disable iff (rst)
      (s_mode && le_rise) |=> (atten_sel == $past(chain_q[CODE_W-1:0])));

   // R4
   chain_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (s_le || !s_mode || !sck_rise) |=> $stable(chain_q));

   // R5
   ser_out_step_chk: assert property (@(posedge clk) disable iff (rst)
      (s_mode && !s_le && sck_rise) |=> (ser_out == $past(chain_q[CHAIN_LEN-2])));

   // R6
   serial_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (s_mode && !le_rise) |=> $stable(atten_sel));

   // R7
   direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (!s_mode && s_le) |=> (atten_sel == $past(s_par)));

   // R8
   par_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (!s_mode && !s_le) |=> $stable(atten_sel));

endmodule

bind atten_ctrl atten_ctrl_chk #(.CODE_W(CODE_W), .CHAIN_LEN(CHAIN_LEN)) i_atten_ctrl_chk (
   .clk       (clk),
   .rst       (rst),
   .s_mode    (s_mode),
   .s_le      (s_le),
   .sck_rise  (sck_rise),
   .le_rise   (le_rise),
   .s_par     (s_par),
   .chain_q   (chain_q),
   .ser_out   (ser_out),
   .atten_sel (atten_sel)
);

// File: tb/test_atten_ctrl.sv
`timescale 1ns/1ps
module test_atten_ctrl;

   localparam int SETTLE = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode_ser = 1'b0;
   logic       latch_en = 1'b0;
   logic [5:0] ctl_pin = 6'd0;
   logic       ser_out;
   logic [5:0] atten_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   atten_ctrl i_atten_ctrl (
      .clk       (clk),
      .rst       (rst),
      .mode_ser  (mode_ser),
      .latch_en  (latch_en),
      .ctl_pin   (ctl_pin),
      .ser_out   (ser_out),
      .atten_sel (atten_sel)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      wait_n(3);
      rst = 1'b0;
      wait_n(SETTLE);
   endtask

   task automatic sclk_bit(input bit b);
      ctl_pin[4] = b;
      wait_n(SETTLE);
      ctl_pin[5] = 1'b1;
      wait_n(SETTLE);
      ctl_pin[5] = 1'b0;
      wait_n(SETTLE);
   endtask

   task automatic ser_word(input int val, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) sclk_bit(val[i]);
   endtask

   task automatic le_pulse();
      latch_en = 1'b1;
      wait_n(SETTLE);
      latch_en = 1'b0;
      wait_n(SETTLE);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_n(4);
      rst = 1'b0;
      wait_n(1);
      // R1: reset state
      chk(atten_sel == 6'd0, "R1 atten", atten_sel, 0);
      chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);

      // R2: every code as a six-bit serial word
      mode_ser = 1'b1;
      wait_n(SETTLE);
      for (int c = 0; c < 64; c++) begin
         ser_word(c, 6);
         le_pulse();
         chk(atten_sel == c[5:0], "R2 serial code", atten_sel, c);
      end

      // R3: eight-bit words, leading two bits vary
      for (int c = 0; c < 64; c++) begin
         int w;
         w = (((c + 1) % 4) << 6) | c;
         ser_word(w, 8);
         le_pulse();
         chk(atten_sel == c[5:0], "R3 8-bit word", atten_sel, c);
      end

      // R6: shifting without a latch leaves the setting
      ser_word(6'h2A, 6);
      le_pulse();
      ser_word(6'h15, 6);
      chk(atten_sel == 6'h2A, "R6 hold no latch", atten_sel, 6'h2A);
      le_pulse();
      chk(atten_sel == 6'h15, "R6 load on latch", atten_sel, 6'h15);

      // R4: clock edges under a high latch are masked
      ser_word(0, 8);
      latch_en = 1'b1;
      wait_n(SETTLE);
      chk(atten_sel == 6'd0, "R4 load zero", atten_sel, 0);
      for (int i = 0; i < 3; i++) sclk_bit(1'b1);
      latch_en = 1'b0;
      wait_n(SETTLE);
      le_pulse();
      chk(atten_sel == 6'd0, "R4 masked shift", atten_sel, 0);
      chk(ser_out == 1'b0, "R4 ser_out masked", ser_out, 0);

      // R5: eight-edge delay from serial input to output
      do_reset();
      mode_ser = 1'b1;
      wait_n(SETTLE);
      begin
         bit [15:0] seq;
         seq = 16'b1011_0010_1110_0101;
         for (int k = 1; k <= 16; k++) begin
            bit exp_b;
            sclk_bit(seq[16-k]);
            exp_b = (k >= 8) ? seq[16-(k-7)] : 1'b0;
            chk(ser_out == exp_b, "R5 ser_out delay", ser_out, exp_b);
         end
      end

      // R9: serial pins toggled in parallel mode do not shift
      do_reset();
      mode_ser = 1'b0;
      latch_en = 1'b0;
      wait_n(SETTLE);
      for (int i = 0; i < 8; i++) sclk_bit(1'b1);
      chk(ser_out == 1'b0, "R9 ser_out parallel", ser_out, 0);
      ctl_pin = 6'd0;
      mode_ser = 1'b1;
      wait_n(SETTLE);
      le_pulse();
      chk(atten_sel == 6'd0, "R9 chain untouched", atten_sel, 0);

      // R7: direct parallel sweep
      mode_ser = 1'b0;
      latch_en = 1'b1;
      for (int v = 0; v < 64; v++) begin
         ctl_pin = v[5:0];
         wait_n(SETTLE);
         chk(atten_sel == v[5:0], "R7 direct", atten_sel, v);
      end

      // R8: latched parallel sweep
      latch_en = 1'b0;
      wait_n(SETTLE);
      begin
         int prev;
         prev = 63;
         for (int v = 0; v < 64; v++) begin
            int nv;
            nv = (v * 37 + 11) % 64;
            ctl_pin = nv[5:0];
            wait_n(SETTLE);
            chk(atten_sel == prev[5:0], "R8 frozen", atten_sel, prev);
            le_pulse();
            ctl_pin = ~nv[5:0];
            wait_n(SETTLE);
            chk(atten_sel == nv[5:0], "R8 latched", atten_sel, nv);
            prev = nv;
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule